// File: doc/BRIEF.md
# CPU Bus Manager with Block-Copy Arbitration

This block sits on a CPU bus with a 16-bit address and 8-bit data. The CPU places the upper address byte (the bank) on the data lines while its clock phase `phi2` is low. The block captures that byte during the low phase and joins it to the 16-bit address to form a 24-bit address. It decodes the bank into active-low chip selects for main memory and three peripherals: I/O, audio and USB. It also exports the held bank to the video unit.

CPU accesses that fall in the main-memory region go out on a request/ready memory port. The CPU is halted for every cycle in which that memory has not answered. A video unit can ask at any time for a block copy from main memory into video memory. The block grants the request at a free CPU cycle boundary and halts the CPU for the whole copy. It then moves the bytes as a burst of reads, each followed by a write on the video port. When the copy ends it pulses done and lets the CPU run again.

The controller is a five-state machine:
- `ST_IDLE`: waits for a cycle boundary.
- `ST_CPU`: a CPU main-memory access.
- `ST_CP_RD`: reads one copy byte from main memory.
- `ST_CP_WR`: writes that byte to video memory.
- `ST_DONE`: the one-cycle done pulse.

Transitions:
- `ST_IDLE`→`ST_CPU` at a boundary with a valid main-memory access.
- `ST_IDLE`→`ST_CP_RD` at a boundary with no such access, a pending video request and a non-zero length.
- `ST_IDLE`→`ST_DONE` in the same case with a zero length.
- `ST_CPU`→`ST_IDLE` on `mem_ready`.
- `ST_CP_RD`→`ST_CP_WR` on `mem_ready`.
- `ST_CP_WR`→`ST_CP_RD` while bytes remain.
- `ST_CP_WR`→`ST_DONE` after the last byte.
- `ST_DONE`→`ST_IDLE` always.

Top module: `cpu_bus_mgr`

## Requirements
- R1: While `phi2` is sampled low, `bank_out` loads `cpu_din` on each clock edge. While `phi2` is sampled high, `bank_out` holds its value.
- R2: The chip selects decode the held bank only while `cpu_valid` is high. `cs_mem_n` goes low for banks 0x00–0xEF, `cs_io_n` for 0xF0, `cs_aud_n` for 0xF1 and `cs_usb_n` for 0xF2. Banks 0xF3–0xFF select nothing. At most one select is low at a time.
- R3: A cycle boundary is a clock edge at which `phi2` is sampled high after being sampled low on the edge before. At a boundary with `cpu_valid` high and a main-memory bank, the next cycle raises `mem_req`. It also drives `mem_addr` = {bank, `cpu_addr`}, `mem_we` = not `cpu_rw` (`cpu_rw` 1 = read) and `mem_wdata` = `cpu_din`, with `mem_burst` low.
- R4: During a CPU access, `cpu_halt` is high exactly in the cycles where `mem_req` is high and `mem_ready` is low. An access answered in its first cycle never halts the CPU.
- R5: On a CPU read, the `mem_rdata` of the ready cycle appears on `cpu_rdata` from the next cycle on.
- R6: An access to a peripheral bank raises neither `mem_req` nor `cpu_halt`.
- R7: `vid_grant` rises only out of `ST_IDLE` at a cycle boundary. A video request raised during a CPU access waits until that access has finished.
- R8: A copy of `vid_len` bytes reads `vid_src`+k from main memory with `mem_burst` high and `mem_we` low. It writes each byte to `vid_dst`+k with `vid_we`, for k ascending from 0. `cpu_halt` stays high for the whole copy.
- R9: After the last byte, `vid_done` is high for exactly one cycle while `cpu_halt` is still high. In the cycle after that, `cpu_halt` and `vid_grant` are low. A zero `vid_len` gives the done pulse with no writes.
- R10: While `vid_grant` is high, `cs_mem_n` is low and `cs_io_n`, `cs_aud_n` and `cs_usb_n` are high, whatever the CPU inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| phi2 | input | 1 | CPU clock phase; low phase carries the bank byte |
| cpu_valid | input | 1 | CPU address is valid in the high phase |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address, low 16 bits |
| cpu_din | input | 8 | CPU data lines (bank byte in low phase, write data in high phase) |
| cpu_rdata | output | 8 | read data returned to the CPU |
| cpu_halt | output | 1 | stalls the CPU |
| bank_out | output | 8 | held bank byte, shared with the video unit |
| cs_mem_n | output | 1 | main-memory chip select, active low |
| cs_io_n | output | 1 | I/O chip select, active low |
| cs_aud_n | output | 1 | audio chip select, active low |
| cs_usb_n | output | 1 | USB chip select, active low |
| mem_req | output | 1 | main-memory request |
| mem_we | output | 1 | main-memory write enable |
| mem_burst | output | 1 | request is part of a sequential copy burst |
| mem_addr | output | 24 | main-memory address |
| mem_wdata | output | 8 | main-memory write data |
| mem_rdata | input | 8 | main-memory read data |
| mem_ready | input | 1 | main memory completes the request this cycle |
| vid_req | input | 1 | video block-copy request (level) |
| vid_src | input | 24 | copy source address in main memory |
| vid_dst | input | 24 | copy destination address in video memory |
| vid_len | input | 16 | copy length in bytes |
| vid_grant | output | 1 | copy in progress, CPU bus taken |
| vid_we | output | 1 | video-memory write strobe |
| vid_addr | output | 24 | video-memory write address |
| vid_wdata | output | 8 | video-memory write data |
| vid_done | output | 1 | one-cycle copy completion pulse |

## Verification
CPU reads are run with zero, one and three memory wait cycles. The count of halted cycles must track the wait count exactly, which separates a halt driven by `mem_ready` from a fixed stall. Writes and peripheral-bank accesses show whether the write enable and data follow the bus and whether only the main-memory region reaches the memory port. A video request raised in the middle of a stalled CPU read shows whether the grant waits for the next boundary. During the copy that follows, the data lines keep a peripheral bank and `cpu_valid` stays high, so any leak of the decoder through the grant mask would show on the selects. A zero-length copy and a four-byte copy with two wait cycles per read check that the done pulse, the halt release and the write count depend on the length.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CPU   = 3'd1,
        ST_CP_RD = 3'd2,
        ST_CP_WR = 3'd3,
        ST_DONE  = 3'd4
    } cbm_state_e;
endpackage

// File: rtl/cbm_bank_latch.sv
module cbm_bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank_q,
    output logic              cyc_start
);
    logic phi2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phi2_q <= 1'b0;
            bank_q <= '0;
        end else begin
            phi2_q <= phi2;
            if (!phi2) bank_q <= din;
        end
    end

    assign cyc_start = phi2 & ~phi2_q;

    // R1: bank held across a high phase
    a_r1_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |=> $stable(bank_q));
endmodule

// File: rtl/cbm_decode.sv
module cbm_decode #(
    parameter int                    BANK_W    = 8,
    parameter int                    N_DEV     = 3,
    parameter logic [BANK_W-1:0]     MEM_LAST  = 8'hEF,
    parameter logic [N_DEV*BANK_W-1:0] DEV_BANKS = {8'hF2, 8'hF1, 8'hF0}
) (
    input  logic [BANK_W-1:0] bank,
    input  logic              valid,
    input  logic              copy_active,
    output logic              mem_hit,
    output logic              mem_cs_n,
    output logic [N_DEV-1:0]  dev_cs_n
);
    assign mem_hit  = valid && (bank <= MEM_LAST);
    assign mem_cs_n = !(copy_active || mem_hit);

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        assign dev_cs_n[i] = !(valid && !copy_active &&
                               (bank == DEV_BANKS[i*BANK_W +: BANK_W]));
    end
endmodule

// File: rtl/cbm_copy_ctr.sv
module cbm_copy_ctr #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic              last
);
    logic [LEN_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            src_q <= src_in;
            dst_q <= dst_in;
            rem_q <= len_in;
        end else if (step) begin
            src_q <= src_q + 1'b1;
            dst_q <= dst_q + 1'b1;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last = (rem_q == LEN_W'(1));
endmodule

// File: rtl/cpu_bus_mgr.sv
module cpu_bus_mgr
    import cbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phi2,
    input  logic                     cpu_valid,
    input  logic                     cpu_rw,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_din,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_halt,
    output logic [BANK_W-1:0]        bank_out,
    output logic                     cs_mem_n,
    output logic                     cs_io_n,
    output logic                     cs_aud_n,
    output logic                     cs_usb_n,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_burst,
    output logic [BANK_W+ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ready,
    input  logic                     vid_req,
    input  logic [BANK_W+ADDR_W-1:0] vid_src,
    input  logic [BANK_W+ADDR_W-1:0] vid_dst,
    input  logic [LEN_W-1:0]         vid_len,
    output logic                     vid_grant,
    output logic                     vid_we,
    output logic [BANK_W+ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0]        vid_wdata,
    output logic                     vid_done
);
    localparam int FULL_W = BANK_W + ADDR_W;
    localparam int N_DEV  = 3;

    cbm_state_e        state, state_nx;
    logic [BANK_W-1:0] bank_q;
    logic              cyc_start, mem_hit, copy_load, copy_step, copy_last;
    logic [N_DEV-1:0]  dev_cs_n;
    logic [FULL_W-1:0] src_q, dst_q;
    logic [DATA_W-1:0] rdata_q, byte_q;

    cbm_bank_latch #(.BANK_W(BANK_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .din(cpu_din[BANK_W-1:0]),
        .bank_q(bank_q), .cyc_start(cyc_start)
    );

    cbm_decode #(.BANK_W(BANK_W), .N_DEV(N_DEV)) u_dec (
        .bank(bank_q), .valid(cpu_valid), .copy_active(vid_grant),
        .mem_hit(mem_hit), .mem_cs_n(cs_mem_n), .dev_cs_n(dev_cs_n)
    );

    cbm_copy_ctr #(.ADDR_W(FULL_W), .LEN_W(LEN_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(copy_load), .step(copy_step),
        .src_in(vid_src), .dst_in(vid_dst), .len_in(vid_len),
        .src_q(src_q), .dst_q(dst_q), .last(copy_last)
    );

    assign cs_io_n  = dev_cs_n[0];
    assign cs_aud_n = dev_cs_n[1];
    assign cs_usb_n = dev_cs_n[2];
    assign bank_out = bank_q;

    assign copy_load = (state == ST_IDLE) && cyc_start && !mem_hit && vid_req;
    assign copy_step = (state == ST_CP_WR);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc_start && mem_hit)
                    state_nx = ST_CPU;
                else if (copy_load)
                    state_nx = (vid_len == '0) ? ST_DONE : ST_CP_RD;
            end
            ST_CPU:   if (mem_ready) state_nx = ST_IDLE;
            ST_CP_RD: if (mem_ready) state_nx = ST_CP_WR;
            ST_CP_WR: state_nx = copy_last ? ST_DONE : ST_CP_RD;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and data captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
            byte_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CPU && mem_ready)   rdata_q <= mem_rdata;
            if (state == ST_CP_RD && mem_ready) byte_q  <= mem_rdata;
        end
    end

    assign cpu_rdata = rdata_q;

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = {bank_q, cpu_addr};
        mem_wdata = cpu_din;
        cpu_halt  = 1'b0;
        vid_grant = 1'b0;
        vid_we    = 1'b0;
        vid_done  = 1'b0;
        vid_addr  = dst_q;
        vid_wdata = byte_q;
        unique case (state)
            ST_IDLE: ;
            ST_CPU: begin
                mem_req  = 1'b1;
                mem_we   = !cpu_rw;
                cpu_halt = !mem_ready;
            end
            ST_CP_RD: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = src_q;
                cpu_halt  = 1'b1;
                vid_grant = 1'b1;
            end
            ST_CP_WR: begin
                vid_we    = 1'b1;
                cpu_halt  = 1'b1;
                vid_grant = 1'b1;
            end
            ST_DONE: begin
                vid_done  = 1'b1;
                cpu_halt  = 1'b1;
                vid_grant = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: never two selects at once
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n}));
    // R4: a waiting CPU request halts the CPU
    a_r4_wait_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_burst && !mem_ready) |-> cpu_halt);
    // R4/R6: no halt without a request or a copy
    a_r4_no_idle_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !vid_grant) |-> !cpu_halt);
    // R7: grant starts only from idle
    a_r7_grant_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_grant) |-> ($past(state) == ST_IDLE));
    // R8: copy reads never write main memory
    a_r8_burst_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_burst |-> (mem_req && !mem_we && cpu_halt));
    // R9: halt released after the done pulse
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        vid_done |=> (!cpu_halt && !vid_grant && !vid_done));
    // R10: peripheral selects quiet during a copy
    a_r10_copy_selects: assert property (@(posedge clk) disable iff (!rst_n)
        vid_grant |-> (!cs_mem_n && cs_io_n && cs_aud_n && cs_usb_n));
endmodule

// File: tb/cpu_bus_mgr_tb.sv
module cpu_bus_mgr_tb;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        phi2 = 1'b0, cpu_valid = 1'b0, cpu_rw = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic [7:0]  cpu_rdata, bank_out, mem_wdata, mem_rdata, vid_wdata;
    logic        cpu_halt, cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n;
    logic        mem_req, mem_we, mem_burst, mem_ready;
    logic [23:0] mem_addr, vid_addr;
    logic        vid_req = 1'b0;
    logic [23:0] vid_src = '0, vid_dst = '0;
    logic [15:0] vid_len = '0;
    logic        vid_grant, vid_we, vid_done;

    int tests = 0, fails = 0;
    int lat = 0, wcnt = 0;
    int vw_cnt = 0, done_cnt = 0, wr_cnt = 0;
    logic [23:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  vmem [256];
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    cpu_bus_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_valid(cpu_valid),
        .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .cpu_rdata(cpu_rdata), .cpu_halt(cpu_halt), .bank_out(bank_out),
        .cs_mem_n(cs_mem_n), .cs_io_n(cs_io_n), .cs_aud_n(cs_aud_n),
        .cs_usb_n(cs_usb_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .vid_req(vid_req),
        .vid_src(vid_src), .vid_dst(vid_dst), .vid_len(vid_len),
        .vid_grant(vid_grant), .vid_we(vid_we), .vid_addr(vid_addr),
        .vid_wdata(vid_wdata), .vid_done(vid_done)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // main-memory and video-memory models
    assign mem_ready = mem_req && (wcnt == lat);
    assign mem_rdata = pat(mem_addr);
    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0; else wcnt <= wcnt + 1;
        if (mem_req && mem_ready && mem_we) begin
            wr_addr <= mem_addr; wr_data <= mem_wdata; wr_cnt <= wr_cnt + 1;
        end
        if (vid_we) begin
            vmem[vid_addr[7:0]] <= vid_wdata; vw_cnt <= vw_cnt + 1;
        end
        if (vid_done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // low phase with a bank byte, then high phase with an access
    task automatic bus_cycle(input logic [7:0] bank, input logic valid,
                             input logic rw, input logic [15:0] a, input logic [7:0] wd);
        @(negedge clk); phi2 = 1'b0; cpu_valid = 1'b0; cpu_din = bank;
        @(negedge clk); phi2 = 1'b1; cpu_valid = valid; cpu_rw = rw;
        cpu_addr = a; cpu_din = wd;
    endtask

    task automatic t_reset();
        check(!cpu_halt, "R4 reset halt", cpu_halt, 0);
        check({cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n} == 4'hF, "R2 reset selects",
              {cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n}, 4'hF);
        check(!mem_req && !vid_grant && !vid_done, "R7 reset idle",
              {mem_req, vid_grant, vid_done}, 0);
    endtask

    task automatic t_bank_latch();
        bus_cycle(8'h3C, 1'b0, 1'b1, 16'h0000, 8'hAA);
        @(negedge clk); @(negedge clk);
        check(bank_out == 8'h3C, "R1 bank held in high phase", bank_out, 8'h3C);
        cpu_din = 8'h77; phi2 = 1'b0;
        @(negedge clk);
        check(bank_out == 8'h77, "R1 bank loads in low phase", bank_out, 8'h77);
    endtask

    task automatic t_decode();
        logic [7:0] banks [5] = '{8'h10, 8'hF0, 8'hF1, 8'hF2, 8'hF5};
        logic [3:0] exp   [5] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110, 4'b1111};
        lat = 0;
        for (int i = 0; i < 5; i++) begin
            bus_cycle(banks[i], 1'b1, 1'b1, 16'h0100, 8'h00);
            @(negedge clk);
            check({cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n} == exp[i], "R2 decode",
                  {cs_mem_n, cs_io_n, cs_aud_n, cs_usb_n}, exp[i]);
            if (i > 0)
                check(!mem_req && !cpu_halt, "R6 peripheral no request",
                      {mem_req, cpu_halt}, 0);
            @(negedge clk); cpu_valid = 1'b0;
        end
    endtask

    task automatic t_cpu_access(input int l, input logic rw, input logic [7:0] bank,
                                input logic [15:0] a, input logic [7:0] wd,
                                input bit raise_vid);
        int halts = 0;
        int wr0 = wr_cnt;
        lat = l;
        bus_cycle(bank, 1'b1, rw, a, wd);
        @(negedge clk);
        check(mem_req && mem_addr == {bank, a} && mem_we == !rw && !mem_burst,
              "R3 request fields", {mem_req, mem_we, mem_addr}, {1'b1, !rw, bank, a});
        if (raise_vid) vid_req = 1'b1;
        for (int g = 0; g < 50 && cpu_halt; g++) begin
            halts++;
            if (raise_vid) check(!vid_grant, "R7 grant waits for CPU access", vid_grant, 0);
            @(negedge clk);
        end
        check(halts == l, "R4 halt cycles equal wait cycles", halts, l);
        @(negedge clk);
        check(!cpu_halt && !mem_req, "R4 halt released", {cpu_halt, mem_req}, 0);
        if (rw) check(cpu_rdata == pat({bank, a}), "R5 read data", cpu_rdata, pat({bank, a}));
        else check(wr_cnt == wr0 + 1 && wr_addr == {bank, a} && wr_data == wd,
                   "R3 write forwarded", wr_data, wd);
        cpu_valid = 1'b0;
    endtask

    task automatic t_copy(input logic [23:0] src, input logic [23:0] dst,
                          input logic [15:0] len, input int l);
        int k = 0, bad_halt = 0, bad_cs = 0, bad_rd = 0, guard = 0;
        int vw0 = vw_cnt, dn0 = done_cnt;
        lat = l; vid_src = src; vid_dst = dst; vid_len = len; vid_req = 1'b1;
        // peripheral bank with valid high: decoder would pick I/O if unmasked
        bus_cycle(8'hF0, 1'b1, 1'b1, 16'h0010, 8'h00);
        @(negedge clk);
        while (!vid_done && guard < 500) begin
            guard++;
            if (!cpu_halt) bad_halt++;
            if (!(cs_io_n && cs_aud_n && cs_usb_n && !cs_mem_n)) bad_cs++;
            if (mem_req && mem_ready) begin
                if (mem_addr != src + 24'(k) || !mem_burst || mem_we) bad_rd++;
                k++;
            end
            @(negedge clk);
        end
        check(vid_done && cpu_halt && vid_grant, "R9 done pulse with halt",
              {vid_done, cpu_halt, vid_grant}, 3'b111);
        check(bad_halt == 0, "R8 halt held during copy", bad_halt, 0);
        check(bad_cs == 0, "R10 selects during copy", bad_cs, 0);
        check(bad_rd == 0 && k == int'(len), "R8 burst reads", k, len);
        check(bank_out == 8'hF0, "R1 bank exported", bank_out, 8'hF0);
        vid_req = 1'b0; cpu_valid = 1'b0;
        @(negedge clk);
        check(!cpu_halt && !vid_grant && !vid_done, "R9 halt released after done",
              {cpu_halt, vid_grant, vid_done}, 0);
        check(vw_cnt == vw0 + int'(len), "R8 write count", vw_cnt - vw0, len);
        check(done_cnt == dn0 + 1, "R9 single done pulse", done_cnt - dn0, 1);
        for (int i = 0; i < int'(len); i++)
            check(vmem[8'(dst + 24'(i))] == pat(src + 24'(i)), "R8 copied byte",
                  vmem[8'(dst + 24'(i))], pat(src + 24'(i)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_latch();
        t_decode();
        t_cpu_access(0, 1'b1, 8'h12, 16'h3456, 8'h00, 0);
        t_cpu_access(1, 1'b1, 8'h01, 16'hBEEF, 8'h00, 0);
        t_cpu_access(3, 1'b0, 8'hEF, 16'h0042, 8'hC3, 0);
        t_cpu_access(3, 1'b1, 8'h20, 16'h1111, 8'h00, 1);
        t_copy(24'h123400, 24'h000080, 16'd4, 2);
        t_copy(24'h050000, 24'h000040, 16'd0, 0);
        t_copy(24'h0700FE, 24'h0000C0, 16'd3, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule